// File: doc/BRIEF.md
# BCD Calendar Clock with Square-Wave Output

This block keeps the time of day and the calendar as binary-coded decimal bytes: seconds, minutes, hours, day of week, date, month and a two-digit year. Hours run either as a 24-hour count or as a 12-hour count with a PM flag. The mode is chosen by a bit that software writes into the hours byte. A slow reference oscillator input, nominally 32.768 kHz, is synchronised into the system clock domain. Its rising edges feed a binary divider, and each divider wrap advances the clock by one second.

All state is reached through a byte port with an internal address pointer. The pointer is loaded directly. It then steps by one after every read or write access and wraps from the top of the map back to zero. Index 0 holds seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year and 7 the control byte. General-purpose RAM bytes fill the rest of the map. The control byte either gates a square wave made from taps of the divider onto an output pin, or parks that pin at a programmed level.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. Stepping past 59 gives 00 and carries into the next field.
- R2: With hours bit 6 at 0 (24-hour mode), hours count 00 to 23. Stepping past 23 gives 00 and advances the day of week and the date. Units-digit carries follow BCD, so 09 is followed by 10.
- R3: With hours bit 6 at 1 (12-hour mode), bits 4:0 hold 01 to 12 in BCD and bit 5 is PM. The count runs 12, 01, …, 11, 12. The PM bit inverts on the step from 11 to 12, and the step from 11 PM to 12 AM advances the day.
- R4: The day-of-week byte counts 1 to 7 and steps from 7 back to 1.
- R5: The date wraps to 01 after 31, 30 (months 04, 06, 09, 11), or after 28 or 29 for month 02. Day 29 is used when the BCD year is a multiple of 4. The wrap advances the month.
- R6: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00. The year holds its value between second ticks.
- R7: Control byte at index 7 keeps only bits 7, 4, 1 and 0 and reads the others as 0. While bit 4 is 0, the square-wave output equals bit 7.
- R8: While control bit 4 is 1, bits 1:0 select the output. The code 00 gives the divider MSB (1 Hz), 01 gives reference/8 (4.096 kHz), 10 gives reference/4 (8.192 kHz) and 11 gives the reference itself (32.768 kHz).
- R9: A write to index 0 clears the divider, so the next second step comes a full 2^DIV_W reference edges later.
- R10: The pointer steps by one after each access, wraps from the last RAM byte (index 63 by default) to 0, and RAM bytes at indices 8 and up store what is written.
- R11: After reset the registers read 00 00 00 01 01 01 00 for indices 0 to 6, the control byte reads 00, and the square-wave output is 0.
- R12: The time advances exactly once per 2^DIV_W rising reference edges and is unchanged in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference oscillator level |
| ptr_ld | input | 1 | Load the address pointer from ptr_val |
| ptr_val | input | ADDR_W | Pointer load value |
| acc_en | input | 1 | Access strobe; the pointer steps afterwards |
| acc_we | input | 1 | Qualifies acc_en as a write |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Byte at the current pointer (combinational) |
| sqw_out | output | 1 | Square-wave or idle-level output (registered) |

## Verification
The hard cases are the carry chains that cross the day boundary: 11 PM to 12 AM, the last day of each month length, leap February and the year wrap. Reaching them from reset would take days of simulated seconds. The stimulus therefore writes a time one second before each boundary through the byte port. That write clears the divider, so exactly one divider period of reference edges later the bench reads every field back. The bench runs the divider at a reduced width so that a second costs only 16 reference edges.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
    } rtc_time_t;

    localparam int NUM_TIME = 7;
    localparam int NUM_REGS = 8;
    localparam int CTRL_IDX = 7;

    function automatic logic [7:0] bcd_inc(input logic [7:0] x);
        if (x[3:0] == 4'd9) return {x[7:4] + 4'd1, 4'd0};
        return x + 8'd1;
    endfunction

    function automatic logic is_leap(input logic [7:0] yr);
        if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mo, input logic [7:0] yr);
        case (mo)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic rtc_time_t calc_next(input rtc_time_t t);
        rtc_time_t n;
        logic c_min, c_hr, c_day, c_mon, c_yr, pm;
        logic [7:0] tmp;
        logic [4:0] h12;
        n = t;
        c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
        if (t.sec == 8'h59) begin
            n.sec = 8'h00; c_min = 1'b1;
        end else n.sec = bcd_inc(t.sec);
        if (c_min) begin
            if (t.min == 8'h59) begin
                n.min = 8'h00; c_hr = 1'b1;
            end else n.min = bcd_inc(t.min);
        end
        if (c_hr) begin
            if (t.hour[6]) begin
                pm  = t.hour[5];
                h12 = t.hour[4:0];
                if (t.hour[4:0] == 5'h12) h12 = 5'h01;
                else if (t.hour[4:0] == 5'h11) begin
                    h12   = 5'h12;
                    c_day = pm;
                    pm    = ~pm;
                end else begin
                    tmp = bcd_inc({3'b000, t.hour[4:0]});
                    h12 = tmp[4:0];
                end
                n.hour = {2'b01, pm, h12};
            end else if (t.hour[5:0] == 6'h23) begin
                n.hour = 8'h00; c_day = 1'b1;
            end else n.hour = bcd_inc({2'b00, t.hour[5:0]});
        end
        if (c_day) begin
            n.dow = (t.dow == 8'h07) ? 8'h01 : t.dow + 8'd1;
            if (t.date == month_len(t.month, t.year)) begin
                n.date = 8'h01; c_mon = 1'b1;
            end else n.date = bcd_inc(t.date);
        end
        if (c_mon) begin
            if (t.month == 8'h12) begin
                n.month = 8'h01; c_yr = 1'b1;
            end else n.month = bcd_inc(t.month);
        end
        if (c_yr) n.year = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
        return n;
    endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_in,
    input  logic       div_clr,
    input  logic       sqw_en,
    input  logic       sqw_idle,
    input  logic [1:0] sqw_sel,
    output logic       sec_tick,
    output logic       sqw_out
);
    logic             ref_m, ref_s, ref_q;
    logic [DIV_W-1:0] div_q;
    logic             ref_rise;
    logic             tap;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_m <= 1'b0;
            ref_s <= 1'b0;
            ref_q <= 1'b0;
        end else begin
            ref_m <= ref_in;
            ref_s <= ref_m;
            ref_q <= ref_s;
        end
    end

    assign ref_rise = ref_s & ~ref_q;
    assign sec_tick = ref_rise & (&div_q) & ~div_clr;

    always_ff @(posedge clk) begin
        if (rst || div_clr) div_q <= '0;
        else if (ref_rise)  div_q <= div_q + 1'b1;
    end

    always_comb begin
        case (sqw_sel)
            2'b00:   tap = div_q[DIV_W-1];
            2'b01:   tap = div_q[2];
            2'b10:   tap = div_q[1];
            default: tap = ref_s;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sqw_out <= 1'b0;
        else     sqw_out <= sqw_en ? tap : sqw_idle;
    end
endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sec_tick,
    input  logic      wr_en,
    input  logic [2:0] wr_idx,
    input  logic [7:0] wr_data,
    output rtc_time_t time_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, dow: 8'h01,
                        date: 8'h01, month: 8'h01, year: 8'h00};
        end else if (wr_en) begin
            case (wr_idx)
                3'd0:    time_q.sec   <= wr_data & 8'h7F;
                3'd1:    time_q.min   <= wr_data & 8'h7F;
                3'd2:    time_q.hour  <= wr_data & 8'h7F;
                3'd3:    time_q.dow   <= wr_data & 8'h07;
                3'd4:    time_q.date  <= wr_data & 8'h3F;
                3'd5:    time_q.month <= wr_data & 8'h1F;
                default: time_q.year  <= wr_data;
            endcase
        end else if (sec_tick) begin
            time_q <= calc_next(time_q);
        end
    end
endmodule

// File: rtl/rtc_ram.sv
module rtc_ram #(
    parameter int DEPTH = 56,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (idx < IDX_W'(DEPTH))) mem[idx] <= wdata;
    end

    assign rdata = (idx < IDX_W'(DEPTH)) ? mem[idx] : 8'h00;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int DIV_W     = 15,
    parameter int RAM_BYTES = 56,
    localparam int ADDR_W   = $clog2(NUM_REGS + RAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_in,
    input  logic              ptr_ld,
    input  logic [ADDR_W-1:0] ptr_val,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    output logic              sqw_out
);
    localparam int LAST = NUM_REGS + RAM_BYTES - 1;
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST);

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ram_idx;
    logic              ctrl_idle, ctrl_en;
    logic [1:0]        ctrl_sel;
    logic              wr_stb, time_wr, sec_wr, ctrl_wr, ram_we;
    logic              sec_tick;
    logic [7:0]        ram_rdata;
    rtc_time_t         time_q;

    assign wr_stb  = acc_en & acc_we;
    assign time_wr = wr_stb & (ptr_q < ADDR_W'(NUM_TIME));
    assign sec_wr  = wr_stb & (ptr_q == '0);
    assign ctrl_wr = wr_stb & (ptr_q == ADDR_W'(CTRL_IDX));
    assign ram_we  = wr_stb & (ptr_q >= ADDR_W'(NUM_REGS));
    assign ram_idx = ptr_q - ADDR_W'(NUM_REGS);

    always_ff @(posedge clk) begin
        if (rst)         ptr_q <= '0;
        else if (ptr_ld) ptr_q <= ptr_val;
        else if (acc_en) ptr_q <= (ptr_q == LAST_A) ? '0 : ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_idle <= 1'b0;
            ctrl_en   <= 1'b0;
            ctrl_sel  <= 2'b00;
        end else if (ctrl_wr) begin
            ctrl_idle <= acc_wdata[7];
            ctrl_en   <= acc_wdata[4];
            ctrl_sel  <= acc_wdata[1:0];
        end
    end

    rtc_prescale #(.DIV_W(DIV_W)) u_prescale (
        .clk      (clk),
        .rst      (rst),
        .ref_in   (ref_in),
        .div_clr  (sec_wr),
        .sqw_en   (ctrl_en),
        .sqw_idle (ctrl_idle),
        .sqw_sel  (ctrl_sel),
        .sec_tick (sec_tick),
        .sqw_out  (sqw_out)
    );

    rtc_timekeep u_timekeep (
        .clk      (clk),
        .rst      (rst),
        .sec_tick (sec_tick & ~time_wr),
        .wr_en    (time_wr),
        .wr_idx   (ptr_q[2:0]),
        .wr_data  (acc_wdata),
        .time_q   (time_q)
    );

    rtc_ram #(.DEPTH(RAM_BYTES), .IDX_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .idx   (ram_idx),
        .wdata (acc_wdata),
        .rdata (ram_rdata)
    );

    always_comb begin
        if (ptr_q >= ADDR_W'(NUM_REGS)) acc_rdata = ram_rdata;
        else begin
            case (ptr_q[2:0])
                3'd0:    acc_rdata = time_q.sec;
                3'd1:    acc_rdata = time_q.min;
                3'd2:    acc_rdata = time_q.hour;
                3'd3:    acc_rdata = time_q.dow;
                3'd4:    acc_rdata = time_q.date;
                3'd5:    acc_rdata = time_q.month;
                3'd6:    acc_rdata = time_q.year;
                default: acc_rdata = {ctrl_idle, 2'b00, ctrl_en, 2'b00, ctrl_sel};
            endcase
        end
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
    parameter int ADDR_W = 6,
    parameter int LAST   = 63
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_en,
    input logic              ptr_ld,
    input logic [ADDR_W-1:0] ptr_q,
    input logic              ctrl_en,
    input logic              ctrl_idle,
    input logic              sqw_out,
    input logic              sec_tick,
    input logic              time_wr,
    input logic              sec_wr,
    input logic [7:0]        sec_v,
    input logic [7:0]        year_v
);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST);

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !ptr_ld) |=> (ptr_q == (($past(ptr_q) == LAST_A) ? '0 : $past(ptr_q) + 1'b1))); // R10
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!acc_en && !ptr_ld) |=> $stable(ptr_q)); // R10
    AST_SQW_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |=> (sqw_out == $past(ctrl_idle))); // R7
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !time_wr && sec_v == 8'h59) |=> (sec_v == 8'h00)); // R1
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !time_wr) |=> $stable(sec_v)); // R12
    AST_YEAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !time_wr) |=> $stable(year_v)); // R6
    AST_CLR_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        sec_wr |=> !sec_tick); // R9
endmodule

bind rtc_calendar rtc_calendar_chk #(.ADDR_W(ADDR_W), .LAST(LAST)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_en    (acc_en),
    .ptr_ld    (ptr_ld),
    .ptr_q     (ptr_q),
    .ctrl_en   (ctrl_en),
    .ctrl_idle (ctrl_idle),
    .sqw_out   (sqw_out),
    .sec_tick  (sec_tick),
    .time_wr   (time_wr),
    .sec_wr    (sec_wr),
    .sec_v     (time_q.sec),
    .year_v    (time_q.year)
);

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
    localparam int PPS  = 16;   // reference edges per second with DIV_W = 4
    localparam int NVEC = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_in = 1'b0;
    logic       ptr_ld = 1'b0;
    logic [5:0] ptr_val = '0;
    logic       acc_en = 1'b0;
    logic       acc_we = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       sqw_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    rtc_calendar #(.DIV_W(4)) u_dut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .ptr_ld(ptr_ld), .ptr_val(ptr_val),
        .acc_en(acc_en), .acc_we(acc_we), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .sqw_out(sqw_out)
    );

    // start sec,min,hour,dow,date,month,year | expected after one second
    localparam logic [111:0] VEC [NVEC] = '{
        {56'h05_00_00_01_01_01_00, 56'h06_00_00_01_01_01_00}, // R1
        {56'h59_59_08_02_10_03_21, 56'h00_00_09_02_10_03_21}, // R1
        {56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00}, // R2
        {56'h59_59_09_01_01_01_01, 56'h00_00_10_01_01_01_01}, // R2
        {56'h59_59_23_03_28_02_23, 56'h00_00_00_04_01_03_23}, // R5
        {56'h59_59_23_03_28_02_24, 56'h00_00_00_04_29_02_24}, // R5
        {56'h59_59_23_04_29_02_24, 56'h00_00_00_05_01_03_24}, // R5
        {56'h59_59_23_05_30_04_22, 56'h00_00_00_06_01_05_22}, // R5
        {56'h59_59_23_06_30_01_22, 56'h00_00_00_07_31_01_22}, // R5
        {56'h59_59_51_02_15_06_20, 56'h00_00_72_02_15_06_20}, // R3
        {56'h59_59_71_02_15_06_20, 56'h00_00_52_03_16_06_20}, // R3
        {56'h59_59_72_02_15_06_20, 56'h00_00_61_02_15_06_20}, // R3
        {56'h59_59_52_02_15_06_20, 56'h00_00_41_02_15_06_20}, // R3
        {56'h59_59_23_07_09_09_09, 56'h00_00_00_01_10_09_09}, // R4
        {56'h59_59_23_04_31_12_19, 56'h00_00_00_05_01_01_20}  // R6
    };

    function automatic string tag_of(input int n);
        case (n)
            0, 1:             return "R1";
            2, 3:             return "R2";
            4, 5, 6, 7, 8:    return "R5";
            9, 10, 11, 12:    return "R3";
            13:               return "R4";
            default:          return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic set_ptr(input logic [5:0] a);
        @(negedge clk);
        ptr_ld = 1'b1; ptr_val = a;
        @(negedge clk);
        ptr_ld = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        acc_en = 1'b1; acc_we = 1'b1; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] d);
        d = acc_rdata;
        acc_en = 1'b1;
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic wr_at(input logic [5:0] a, input logic [7:0] d);
        set_ptr(a);
        wr_byte(d);
    endtask

    task automatic rd_at(input logic [5:0] a, output logic [7:0] d);
        set_ptr(a);
        d = acc_rdata;
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) begin
            ref_in = 1'b1;
            repeat (4) @(negedge clk);
            ref_in = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R12: watchdog expired, actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset values
        check("R11", sqw_out, 8'h00);
        set_ptr(0);
        for (int i = 0; i < 8; i++) begin
            rd_byte(v);
            check("R11", v, (i >= 3 && i <= 5) ? 8'h01 : 8'h00);
        end

        // table of one-second steps across carry boundaries
        for (int n = 0; n < NVEC; n++) begin
            set_ptr(0);
            for (int i = 0; i < 7; i++) wr_byte(VEC[n][111 - 8*i -: 8]);
            pulses(PPS);
            set_ptr(0);
            for (int i = 0; i < 7; i++) begin
                rd_byte(v);
                check(tag_of(n), v, VEC[n][55 - 8*i -: 8]);
            end
        end

        // R9 / R12: seconds write restarts the divider
        wr_at(0, 8'h00);
        pulses(5);
        wr_at(0, 8'h10);
        pulses(11);
        rd_at(0, v); check("R9", v, 8'h10);
        pulses(4);
        rd_at(0, v); check("R12", v, 8'h10);
        pulses(1);
        rd_at(0, v); check("R12", v, 8'h11);

        // R10: RAM storage, auto-increment and wrap
        set_ptr(62);
        wr_byte(8'h11);
        wr_byte(8'hA5);        // index 63, pointer wraps to 0
        wr_byte(8'h33);        // lands on seconds
        wr_at(8, 8'h3C);
        rd_at(62, v); check("R10", v, 8'h11);
        rd_at(63, v); check("R10", v, 8'hA5);
        rd_at(8, v);  check("R10", v, 8'h3C);
        rd_at(0, v);  check("R10", v, 8'h33);

        // R7: control masking and idle level
        wr_at(7, 8'hFF);
        rd_at(7, v); check("R7", v, 8'h93);
        wr_at(7, 8'h80);
        @(negedge clk);
        check("R7", {7'd0, sqw_out}, 8'h01);
        wr_at(7, 8'h00);
        @(negedge clk);
        check("R7", {7'd0, sqw_out}, 8'h00);

        // R8: frequency taps
        wr_at(7, 8'h10); wr_at(0, 8'h00); @(negedge clk);
        check("R8", {7'd0, sqw_out}, 8'h00);
        pulses(7); check("R8", {7'd0, sqw_out}, 8'h00);
        pulses(1); check("R8", {7'd0, sqw_out}, 8'h01);

        wr_at(7, 8'h11); wr_at(0, 8'h00); @(negedge clk);
        pulses(3); check("R8", {7'd0, sqw_out}, 8'h00);
        pulses(1); check("R8", {7'd0, sqw_out}, 8'h01);

        wr_at(7, 8'h12); wr_at(0, 8'h00); @(negedge clk);
        pulses(1); check("R8", {7'd0, sqw_out}, 8'h00);
        pulses(1); check("R8", {7'd0, sqw_out}, 8'h01);

        wr_at(7, 8'h13);
        ref_in = 1'b1; repeat (4) @(negedge clk);
        check("R8", {7'd0, sqw_out}, 8'h01);
        ref_in = 1'b0; repeat (4) @(negedge clk);
        check("R8", {7'd0, sqw_out}, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule